// File: doc/BRIEF.md
# Vedic Carry-Save 8x8 Multiplier

This block forms the exact 16-bit product of two unsigned 8-bit operands. Each operand is split into a high and a low nibble. Four 4x4 sub-multipliers form the crosswise partial products. Each sub-multiplier is itself assembled from four 2x2 crosswise cells. Two cascaded carry-save stages fold the weighted partial products into one sum vector and one carry vector. A logarithmic-depth parallel-prefix adder then resolves these into the final product.

The result can be taken straight from the adder or through an output register, selected by a parameter. With the register in place, operands presented before a rising clock edge appear as a product after that edge. An active-low reset clears the register at a clock edge. The block suits datapaths that need an unsigned byte product with a short, balanced critical path.

Top module: `vm_mul8`

## Requirements
- R1: For every one of the 65536 unsigned operand pairs, `product` equals `op_a` times `op_b` exactly.
- R2: With `REG_OUT` = 1 (the default), the product of the operands sampled at a rising clock edge is presented on `product` right after that edge, and it holds until the next edge.
- R3: With `REG_OUT` = 1, `rst_n` low at a rising edge forces `product` to 0 after that edge, whatever the operands are.
- R4: When either operand is 0, `product` is 0.
- R5: When `op_a` is 1, `product` equals `op_b` zero-extended to 16 bits.
- R6: The largest result, 255 times 255, is 16'hFE01, and no product ever exceeds it.
- R7: Swapping the two operands gives the same product.
- R8: Bit 0 of `product` equals the AND of bit 0 of the two operands.
- R9: While both operands are held constant with reset high, `product` stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| product | output | 16 | Unsigned product, registered when `REG_OUT` = 1 |

## Verification
Two things can happen at the same clock edge: the register loads a freshly computed product, and reset clears it. The bench provokes this by holding non-zero operands while it asserts reset in the middle of the run. It then expects 0 one edge later, and expects the true product one edge after reset is released. The second collision is inside the carry-save tree. There, the carries from both compression stages land in the same column. All-ones operands and the exhaustive sweep drive the prefix adder through its longest carry chain, and every result is judged against a shift-and-add reference function.

// File: rtl/vm_pkg.sv
// Package vm_pkg
// Shared widths for the crosswise multiplier. Assumes the operand width is
// a multiple of four, so that it splits evenly into nibble-wide halves.
package vm_pkg;
    localparam int unsigned OP_W   = 8;
    localparam int unsigned HALF_W = OP_W / 2;
    localparam int unsigned PROD_W = 2 * OP_W;
    localparam int unsigned SUB_W  = 2 * HALF_W;

    typedef logic [OP_W-1:0]   operand_t;
    typedef logic [PROD_W-1:0] product_t;
    typedef logic [SUB_W-1:0]  subprod_t;
endpackage

// File: rtl/vm_cell2.sv
// Module vm_cell2
// A 2x2 unsigned crosswise multiplier cell. It forms the vertical and
// crosswise bit products and combines them with two half-adders. Purely
// combinational; it assumes no timing relation between its inputs.
module vm_cell2 (
    input  logic [1:0] x,
    input  logic [1:0] y,
    output logic [3:0] p
);
    logic v0, v1, c0, c1, hc;

    // Form the vertical and crosswise bit products.
    always_comb begin
        v0 = x[0] & y[0];
        v1 = x[1] & y[1];
        c0 = x[1] & y[0];
        c1 = x[0] & y[1];
    end

    // Combine the bit products with two half-adders.
    always_comb begin
        hc   = c0 & c1;
        p[0] = v0;
        p[1] = c0 ^ c1;
        p[2] = v1 ^ hc;
        p[3] = v1 & hc;
    end
endmodule

// File: rtl/vm_mul4.sv
// Module vm_mul4
// A 4x4 unsigned multiplier built from four 2x2 crosswise cells. The cell
// results are weighted by 0, 2 (two cross terms) and 4 bit places and then
// summed by a small adder. Purely combinational.
module vm_mul4 (
    input  logic [3:0] x,
    input  logic [3:0] y,
    output logic [7:0] p
);
    logic [3:0] q [0:3];

    // Index bit 1 picks the half of x and bit 0 the half of y: ll, lh, hl, hh.
    for (genvar k = 0; k < 4; k++) begin : g_cell
        vm_cell2 u_cell (
            .x (x[2*(k/2) +: 2]),
            .y (y[2*(k%2) +: 2]),
            .p (q[k])
        );
    end

    // Merge the weighted cell results.
    always_comb begin
        p = {4'b0, q[0]}
          + {2'b0, q[1], 2'b0}
          + {2'b0, q[2], 2'b0}
          + {q[3], 4'b0};
    end
endmodule

// File: rtl/vm_csa.sv
// Module vm_csa
// A W-bit carry-save adder built from a row of full adders. The carry
// vector is returned unshifted; the caller applies its one-place weight.
module vm_csa #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    for (genvar i = 0; i < W; i++) begin : g_fa
        // One full adder per column.
        assign s[i]  = a[i] ^ b[i] ^ c[i];
        assign cy[i] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end
endmodule

// File: rtl/vm_ks_adder.sv
// Module vm_ks_adder
// A W-bit Kogge-Stone parallel-prefix adder with no carry in. The carry out
// of the top bit is dropped, since the caller guarantees the sum fits in W
// bits.
module vm_ks_adder #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int unsigned LVL = $clog2(W);

    logic [W-1:0] gen [0:LVL];
    logic [W-1:0] prp [0:LVL];

    // Bit-level generate and propagate signals.
    assign gen[0] = a & b;
    assign prp[0] = a ^ b;

    for (genvar k = 0; k < LVL; k++) begin : g_lvl
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= (1 << k)) begin : g_op
                // Prefix operator combining spans at distance 2^k.
                assign gen[k+1][i] = gen[k][i] | (prp[k][i] & gen[k][i-(1<<k)]);
                assign prp[k+1][i] = prp[k][i] & prp[k][i-(1<<k)];
            end else begin : g_pass
                // Bits with no partner at this distance pass through.
                assign gen[k+1][i] = gen[k][i];
                assign prp[k+1][i] = prp[k][i];
            end
        end
    end

    // Final sum: propagate XOR the group carry into each bit.
    assign sum = prp[0] ^ {gen[LVL][W-2:0], 1'b0};
endmodule

// File: rtl/vm_mul8.sv
// Module vm_mul8
// An unsigned 8x8 crosswise multiplier. Four 4x4 sub-products are weighted
// at bit 0 (low x low), bit 4 (both cross terms) and bit 8 (high x high).
// Two carry-save stages reduce them to a sum vector and a carry vector, and
// a Kogge-Stone adder resolves the pair. REG_OUT selects an output register
// with a synchronous active-low reset. Operands are assumed to be stable for
// setup before the clock edge when the register is used.
module vm_mul8
    import vm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  op_a,
    input  logic [7:0]  op_b,
    output logic [15:0] product
);
    subprod_t sp [0:3];
    product_t w0, w1, w2, w3;
    product_t s1, c1, s2, c2, raw;

    // Sub-products indexed by operand halves: ll, lh, hl, hh.
    for (genvar k = 0; k < 4; k++) begin : g_sub
        vm_mul4 u_sub (
            .x (op_a[HALF_W*(k/2) +: HALF_W]),
            .y (op_b[HALF_W*(k%2) +: HALF_W]),
            .p (sp[k])
        );
    end

    // Place each sub-product at its column weight.
    always_comb begin
        w0 = {{(PROD_W-SUB_W){1'b0}}, sp[0]};
        w1 = {{(PROD_W-SUB_W-HALF_W){1'b0}}, sp[1], {HALF_W{1'b0}}};
        w2 = {{(PROD_W-SUB_W-HALF_W){1'b0}}, sp[2], {HALF_W{1'b0}}};
        w3 = {sp[3], {OP_W{1'b0}}};
    end

    vm_csa #(.W(PROD_W)) u_csa1 (
        .a  (w0),
        .b  (w1),
        .c  (w2),
        .s  (s1),
        .cy (c1)
    );

    vm_csa #(.W(PROD_W)) u_csa2 (
        .a  (s1),
        .b  ({c1[PROD_W-2:0], 1'b0}),
        .c  (w3),
        .s  (s2),
        .cy (c2)
    );

    vm_ks_adder #(.W(PROD_W)) u_cpa (
        .a   (s2),
        .b   ({c2[PROD_W-2:0], 1'b0}),
        .sum (raw)
    );

    if (REG_OUT) begin : g_reg
        // Capture the resolved product; clear it in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) product <= '0;
            else        product <= raw;
        end
    end else begin : g_comb
        // Drive the product straight from the adder.
        assign product = raw;
    end
endmodule

// File: rtl/vm_mul8_chk.sv
// Module vm_mul8_chk
// Property checker for vm_mul8, attached by bind. It keeps its own copy of
// the sampled operands so that the properties line up with the output
// register when REG_OUT is set.
module vm_mul8_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  op_a,
    input logic [7:0]  op_b,
    input logic [15:0] product
);
    logic [7:0]  a_q, b_q, a_v, b_v;
    logic [15:0] ref_v;

    // Remember the operands the output register saw.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= op_a;
            b_q <= op_b;
        end
    end

    // Select the operands that the current product belongs to.
    always_comb begin
        a_v   = REG_OUT ? a_q : op_a;
        b_v   = REG_OUT ? b_q : op_b;
        ref_v = 16'(a_v) * 16'(b_v);
    end

    // R1
    exact_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        product == ref_v);

    // R4
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_v == 8'd0 || b_v == 8'd0) |-> product == 16'd0);

    // R5
    unit_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_v == 8'd1) |-> product == {8'd0, b_v});

    // R6
    upper_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        product <= 16'hFE01);

    // R8
    low_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        product[0] == (a_v[0] & b_v[0]));

    if (REG_OUT) begin : g_reg_props
        // R3
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> product == 16'd0);

        // R9
        hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(op_a) && $stable(op_b)) |=> $stable(product));
    end
endmodule

bind vm_mul8 vm_mul8_chk #(.REG_OUT(REG_OUT)) u_vm_mul8_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
);

// File: tb/tb_vm_mul8.sv
// Bench for vm_mul8 with the output register enabled: exhaustive sweep,
// seeded random pairs and directed corner cases.
module tb_vm_mul8;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_a = 8'd0;
    logic [7:0]  op_b = 8'd0;
    logic [15:0] product;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vm_mul8 #(.REG_OUT(1'b1)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    // Shift-and-add reference model.
    function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] acc = 16'd0;
        for (int i = 0; i < 8; i++)
            if (b[i]) acc = acc + (16'(a) << i);
        return acc;
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive a pair at a falling edge; the product is visible at the next one.
    task automatic apply(input logic [7:0] a, input logic [7:0] b);
        op_a = a;
        op_b = b;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] p1;
        void'($urandom(32'd17));
        // R3: reset with non-zero operands keeps the product at 0.
        op_a = 8'd77;
        op_b = 8'd91;
        repeat (3) @(negedge clk);
        check("R3 reset state", product, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: first product after release is for the held operands.
        check("R2 first load", product, ref_mul(8'd77, 8'd91));

        // R6: all-ones operands give the largest product.
        apply(8'hFF, 8'hFF);
        check("R6 max product", product, 16'hFE01);
        // R4: zero operands.
        apply(8'd0, 8'hA5);
        check("R4 zero a", product, 16'd0);
        apply(8'h5A, 8'd0);
        check("R4 zero b", product, 16'd0);
        // R5: unit operand.
        apply(8'd1, 8'hC3);
        check("R5 unit a", product, 16'h00C3);
        // R8: low bit from odd operands.
        apply(8'd3, 8'd5);
        check("R8 low bit", {15'd0, product[0]}, 16'd1);

        // R9: held operands keep the product steady.
        apply(8'd200, 8'd123);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 hold", product, ref_mul(8'd200, 8'd123));
        end

        // R3: reset collides with a non-zero load.
        op_a = 8'd200;
        op_b = 8'd200;
        rst_n = 1'b0;
        @(negedge clk);
        check("R3 mid-run reset", product, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reload after reset", product, ref_mul(8'd200, 8'd200));

        // R7: random pairs checked in both orders.
        for (int i = 0; i < 1000; i++) begin
            logic [7:0] ra, rb;
            ra = 8'($urandom);
            rb = 8'($urandom);
            apply(ra, rb);
            p1 = product;
            check("R1 random", p1, ref_mul(ra, rb));
            apply(rb, ra);
            check("R7 swapped", product, p1);
        end

        // R1: exhaustive sweep of every operand pair.
        for (int i = 0; i < 65536; i++) begin
            apply(8'(i >> 8), 8'(i));
            check("R1 exhaustive", product, ref_mul(8'(i >> 8), 8'(i)));
        end

        finish_run();
    end
endmodule